// File: doc/BRIEF.md
# Stereo Peak Level Meter

This block watches two streams of signed 24-bit audio samples, one for the left channel and one for the right. For each channel it keeps the largest magnitude seen since that channel was last read. It reports the held peak as a 6-bit attenuation code: 0 stands for full scale, each step is 1 dB lower, and 63 stands for -63 dB or quieter, including no signal at all.

Software, or a control-port engine, reads the two peaks through a read strobe and a 4-bit address. The answer is a 16-bit word that repeats the address in its top nibble. A read empties the channel it returns, so each read reports the loudest level since the previous read of that channel. A single enable input gates all tracking.

Top module: `peak_meter_regs`

## Requirements
- R1: A synchronous active-high `rst` empties both held peaks and sets `rd_data` to 0.
- R2: A sample's magnitude is its two's-complement absolute value over 23 bits, and the most negative input, -8388608, saturates to 8388607.
- R3: The code is the count of thresholds T1..T63 that the held magnitude is strictly below. T0 = 8388607 and Tk = floor(Tk-1 * 58409 / 65536). So full scale gives 0 and a magnitude of 0 (no signal) gives 63.
- R4: While enabled and not read, a channel's held magnitude only grows: a valid sample replaces it only when the sample is larger.
- R5: A strobe at address 3 (left) or 4 (right) loads `rd_data` at the next clock edge with {address[3:0], 6'b000000, code[5:0]}. Bits 11..6 are always 0, and `rd_data` holds its value on cycles with no strobe.
- R6: A read at address 3 or 4 empties that channel only, so the channel reads 63 until a new sample arrives.
- R7: When a read and a valid sample for the same channel fall in one cycle, the read returns the code held before that sample, and the held value restarts at that sample's magnitude.
- R8: A strobe at any address other than 3 or 4 loads `rd_data` with 0 and leaves both held peaks unchanged.
- R9: While `meter_en` is 0, samples are ignored and both held peaks are empty, so any read reports code 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meter_en | input | 1 | Enables peak tracking |
| l_valid | input | 1 | Left sample strobe |
| l_data | input | 24 | Left signed sample |
| r_valid | input | 1 | Right sample strobe |
| r_data | input | 24 | Right signed sample |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Readback word |

## Verification
A sample presented with its strobe reaches the held peak at the next edge. It can be read in the cycle after that, and the read result shows on `rd_data` one edge after the strobe. The bench therefore drives every input on the falling clock edge and checks `rd_data` on the falling edge that follows the strobe, once the single rising edge in between has loaded it. The same-cycle case drives the strobe and the sample on the same falling edge. It then checks both the returned code and the value a second read returns. Expected codes come from the bench's own model of the threshold recurrence.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;

    typedef logic [WORD_W-1:0] word_t;

    // Threshold k of the 1 dB ladder: full scale scaled k times by mul/2^shift.
    function automatic longint step_threshold(longint fs, int k, longint mul, int shift);
        longint t;
        t = fs;
        for (int i = 0; i < k; i++) begin
            t = (t * mul) >>> shift;
        end
        return t;
    endfunction
endpackage

// File: rtl/pm_magnitude.sv
module pm_magnitude #(
    parameter int DATA_W = 24,
    localparam int MAG_W = DATA_W - 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [MAG_W-1:0]  mag_o
);
    logic [DATA_W-1:0] neg;

    always_comb begin
        neg = ~data_i + 1'b1;
        if (!data_i[DATA_W-1]) begin
            mag_o = data_i[MAG_W-1:0];
        end else if (data_i[MAG_W-1:0] == '0) begin
            mag_o = '1;                       // most negative value saturates
        end else begin
            mag_o = neg[MAG_W-1:0];
        end
    end

    // R2: any nonzero sample has a nonzero magnitude
    always_comb begin
        if (data_i != '0) begin
            a_r2_nonzero_mag: assert (mag_o != '0);
        end
    end
endmodule

// File: rtl/pm_db_quantizer.sv
module pm_db_quantizer #(
    parameter int MAG_W      = 23,
    parameter int NUM_STEPS  = 63,
    parameter longint STEP_MUL = 58409,
    parameter int STEP_SHIFT = 16,
    localparam int CODE_W    = $clog2(NUM_STEPS + 1)
) (
    input  logic [MAG_W-1:0]  mag_i,
    output logic [CODE_W-1:0] code_o
);
    localparam longint FULL = (longint'(1) << MAG_W) - 1;

    logic [NUM_STEPS-1:0] below;

    for (genvar k = 1; k <= NUM_STEPS; k++) begin : g_step
        localparam longint TH = pm_pkg::step_threshold(FULL, k, STEP_MUL, STEP_SHIFT);
        localparam logic [MAG_W-1:0] TH_V = MAG_W'(TH);
        assign below[k-1] = (mag_i < TH_V);
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_STEPS; i++) begin
            code_o = code_o + CODE_W'(below[i]);
        end
    end

    // R3: thresholds fall with k, so the comparator outputs form a thermometer
    always_comb begin
        for (int i = 1; i < NUM_STEPS; i++) begin
            if (below[i]) begin
                a_r3_thermometer: assert (below[i-1]);
            end
        end
        if (mag_i == '1) begin
            a_r3_full_scale: assert (code_o == '0);
        end
        if (mag_i == '0) begin
            a_r3_silence: assert (code_o == CODE_W'(NUM_STEPS));
        end
    end
endmodule

// File: rtl/pm_peak_hold.sv
module pm_peak_hold #(
    parameter int MAG_W = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             valid_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic             clr_i,
    output logic [MAG_W-1:0] held_o
);
    logic [MAG_W-1:0] held_d, held_q;

    always_comb begin
        held_d = held_q;
        if (!en_i) begin
            held_d = '0;
        end else if (clr_i) begin
            held_d = valid_i ? mag_i : '0;   // read restarts from a coincident sample
        end else if (valid_i && (mag_i > held_q)) begin
            held_d = mag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= held_d;
    end

    assign held_o = held_q;

    a_r4_monotone: assert property (@(posedge clk) disable iff (rst)
        (en_i && !clr_i) |=> (held_q >= $past(held_q)));
    a_r6_cleared: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !valid_i) |=> (held_q == '0));
    a_r7_restart: assert property (@(posedge clk) disable iff (rst)
        (en_i && clr_i && valid_i) |=> (held_q == $past(mag_i)));
    a_r9_disabled_empty: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (held_q == '0));
endmodule

// File: rtl/peak_meter_regs.sv
module peak_meter_regs #(
    parameter int DATA_W     = 24,
    parameter int NUM_STEPS  = 63,
    parameter longint STEP_MUL = 58409,
    parameter int STEP_SHIFT = 16,
    parameter logic [3:0] ADDR_LEFT  = 4'd3,
    parameter logic [3:0] ADDR_RIGHT = 4'd4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        meter_en,
    input  logic        l_valid,
    input  logic [23:0] l_data,
    input  logic        r_valid,
    input  logic [23:0] r_data,
    input  logic        rd_stb,
    input  logic [3:0]  rd_addr,
    output logic [15:0] rd_data
);
    localparam int MAG_W  = DATA_W - 1;
    localparam int CODE_W = $clog2(NUM_STEPS + 1);
    localparam int NUM_CH = 2;
    localparam int PAD_W  = pm_pkg::WORD_W - pm_pkg::ADDR_W - CODE_W;

    typedef struct packed {
        pm_pkg::word_t rd_word;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_CH-1:0]             ch_valid;
    logic [NUM_CH-1:0]             ch_clr;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_data;
    logic [NUM_CH-1:0][MAG_W-1:0]  ch_mag;
    logic [NUM_CH-1:0][MAG_W-1:0]  ch_held;
    logic [NUM_CH-1:0][CODE_W-1:0] ch_code;

    assign ch_valid = {r_valid, l_valid};
    assign ch_data  = {DATA_W'(r_data), DATA_W'(l_data)};
    assign ch_clr   = {rd_stb && (rd_addr == ADDR_RIGHT),
                       rd_stb && (rd_addr == ADDR_LEFT)};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pm_magnitude #(.DATA_W(DATA_W)) u_mag (
            .data_i (ch_data[c]),
            .mag_o  (ch_mag[c])
        );
        pm_peak_hold #(.MAG_W(MAG_W)) u_hold (
            .clk     (clk),
            .rst     (rst),
            .en_i    (meter_en),
            .valid_i (ch_valid[c]),
            .mag_i   (ch_mag[c]),
            .clr_i   (ch_clr[c]),
            .held_o  (ch_held[c])
        );
        pm_db_quantizer #(
            .MAG_W      (MAG_W),
            .NUM_STEPS  (NUM_STEPS),
            .STEP_MUL   (STEP_MUL),
            .STEP_SHIFT (STEP_SHIFT)
        ) u_quant (
            .mag_i  (ch_held[c]),
            .code_o (ch_code[c])
        );
    end

    always_comb begin
        state_d = state_q;
        if (rd_stb) begin
            if (rd_addr == ADDR_LEFT) begin
                state_d.rd_word = {ADDR_LEFT, PAD_W'(0), ch_code[0]};
            end else if (rd_addr == ADDR_RIGHT) begin
                state_d.rd_word = {ADDR_RIGHT, PAD_W'(0), ch_code[1]};
            end else begin
                state_d.rd_word = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rd_data = state_q.rd_word;

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[11:6] == 6'd0);
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));
    a_r8_bad_addr: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr != ADDR_LEFT && rd_addr != ADDR_RIGHT) |=> (rd_data == 16'd0));
    a_r8_no_clear: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && !l_valid && meter_en && $past(meter_en)) |=> $stable(ch_held[0]));
endmodule

// File: tb/sim_peak_meter_regs.sv
module sim_peak_meter_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        meter_en = 1'b0;
    logic        l_valid = 1'b0, r_valid = 1'b0, rd_stb = 1'b0;
    logic [23:0] l_data = '0, r_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    peak_meter_regs u0 (.*);

    typedef struct packed {
        logic        lv;
        logic [23:0] ld;
        logic        rv;
        logic [23:0] rd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 24'h7FFFFF, 1'b1, 24'hFFFFFF},
        '{1'b1, 24'h800000, 1'b0, 24'h000000},
        '{1'b1, 24'h400000, 1'b1, 24'hC00000},
        '{1'b1, 24'h000001, 1'b1, 24'd100000},
        '{1'b1, -24'sd5000, 1'b1, 24'd2000000},
        '{1'b0, 24'h000000, 1'b1, 24'h7FFFFF},
        '{1'b1, 24'd700000, 1'b1, -24'sd300000},
        '{1'b1, 24'd12345,  1'b1, -24'sd12345}
    };

    function automatic int mag_of(logic [23:0] d);
        int v = $signed(d);
        if (v < 0) v = -v;
        if (v > 8388607) v = 8388607;
        return v;
    endfunction

    function automatic int code_of(int m);
        longint t = 8388607;
        int c = 0;
        for (int k = 1; k <= 63; k++) begin
            t = (t * 58409) / 65536;
            if (m < t) c++;
        end
        return c;
    endfunction

    function automatic logic [15:0] word_of(logic [3:0] a, int c);
        return {a, 6'd0, 6'(c)};
    endfunction

    task automatic check(string req, logic [15:0] exp);
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h", req, rd_data, exp);
        end
    endtask

    task automatic drive(logic lv, logic [23:0] ld, logic rv, logic [23:0] rd);
        @(negedge clk);
        l_valid = lv; l_data = ld; r_valid = rv; r_data = rd;
        @(negedge clk);
        l_valid = 0; r_valid = 0;
    endtask

    task automatic read_chk(logic [3:0] a, logic [15:0] exp, string req);
        @(negedge clk);
        rd_stb = 1; rd_addr = a;
        @(negedge clk);
        rd_stb = 0;
        check(req, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset word", 16'h0000);
        rst = 0; meter_en = 1;
        read_chk(4'd3, 16'h303F, "R1 left empty after reset");
        read_chk(4'd4, 16'h403F, "R1 right empty after reset");

        // table walk: R2/R3/R5/R6
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].lv, VECS[i].ld, VECS[i].rv, VECS[i].rd);
            read_chk(4'd3, word_of(4'd3, VECS[i].lv ? code_of(mag_of(VECS[i].ld)) : 63), "R3 left code");
            read_chk(4'd4, word_of(4'd4, VECS[i].rv ? code_of(mag_of(VECS[i].rd)) : 63), "R3 right code");
        end

        // R2 saturation and R3 ends of the scale
        drive(1, 24'h800000, 0, 0);
        read_chk(4'd3, 16'h3000, "R2 most negative saturates to full scale");
        drive(1, 24'h000000, 0, 0);
        read_chk(4'd3, 16'h303F, "R3 zero sample reads 63");

        // R4 max hold
        drive(1, 24'd100000, 0, 0);
        drive(1, 24'd5000000, 0, 0);
        drive(1, 24'd200, 0, 0);
        read_chk(4'd3, word_of(4'd3, code_of(5000000)), "R4 holds the maximum");
        // R6 cleared by the read
        read_chk(4'd3, 16'h303F, "R6 cleared after read");

        // R5 idle hold
        drive(0, 0, 1, 24'd3000000);
        read_chk(4'd4, word_of(4'd4, code_of(3000000)), "R5 right word");
        @(negedge clk);
        check("R5 word held without strobe", word_of(4'd4, code_of(3000000)));

        // R7 same-cycle read and sample
        drive(1, 24'd5000000, 0, 0);
        @(negedge clk);
        rd_stb = 1; rd_addr = 4'd3; l_valid = 1; l_data = 24'd1000;
        @(negedge clk);
        rd_stb = 0; l_valid = 0;
        check("R7 returns value before sample", word_of(4'd3, code_of(5000000)));
        read_chk(4'd3, word_of(4'd3, code_of(1000)), "R7 restarts from sample");

        // R8 bad address
        drive(1, 24'd6000000, 1, 24'd40000);
        read_chk(4'd5, 16'h0000, "R8 bad address reads zero");
        read_chk(4'd15, 16'h0000, "R8 bad address 15 reads zero");
        read_chk(4'd3, word_of(4'd3, code_of(6000000)), "R8 left unchanged");
        read_chk(4'd4, word_of(4'd4, code_of(40000)), "R8 right unchanged");

        // R9 enable low
        drive(1, 24'd6000000, 0, 0);
        @(negedge clk); meter_en = 0;
        @(negedge clk); meter_en = 1;
        read_chk(4'd3, 16'h303F, "R9 disable empties held peak");
        meter_en = 0;
        drive(1, 24'h7FFFFF, 1, 24'h7FFFFF);
        read_chk(4'd3, 16'h303F, "R9 left sample ignored while disabled");
        read_chk(4'd4, 16'h403F, "R9 right sample ignored while disabled");
        meter_en = 1;

        // R1 reset mid-run
        drive(1, 24'h7FFFFF, 1, 24'h7FFFFF);
        @(negedge clk); rst = 1;
        @(negedge clk);
        check("R1 reset clears readback", 16'h0000);
        rst = 0;
        read_chk(4'd3, 16'h303F, "R1 reset empties left");
        read_chk(4'd4, 16'h403F, "R1 reset empties right");

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule